// File: doc/BRIEF.md
# Sync-Word-Gated Bit Receive FIFO

This block sits behind a bit recovery stage. It watches a serial bit stream that arrives with a one-cycle valid strobe per bit. It keeps a running window of the most recent sixteen bits and compares that window with a synchronization word on every strobe. The upper byte of the word is fixed at 0x2D and the lower byte comes from configuration. Once the word has been seen, every later bit goes into a sixteen-entry, one-bit-wide FIFO. A configuration bit can instead make the FIFO store every bit from the moment it is enabled, without waiting for the word.

A level interrupt stays high while the number of stored bits is at or above a programmed threshold. A sticky overflow flag records bits that had to be dropped because the FIFO was full. A host reads the FIFO and a status byte through a four-wire serial port that is sampled in the system clock domain. Clearing or disabling the FIFO empties it and drops the sync lock, so the next packet must carry a fresh synchronization word.

Top module: `rxSyncFifo`

## Requirements
- R1: The FIFO stores up to 16 bits and returns them in arrival order. The stored bit count never exceeds 16.
- R2: With cfgAlwaysFill low, no bit is stored until the 16 most recent strobed bits equal {0x2D, cfgSyncLow}, with the oldest bit in the MSB. The bits of the synchronization word itself are not stored; the bits after it are.
- R3: With cfgAlwaysFill high and cfgFifoEn high, every strobed bit is stored, without any synchronization word.
- R4: fillIrq is high exactly while the stored count is greater than or equal to cfgThreshold (range 1 to 15). It rises in the cycle the threshold-reaching bit is stored and falls once reads bring the count below the threshold.
- R5: A bit strobed while 16 bits are stored is dropped and sets overflow. overflow stays high until a status command is decoded. That status byte reports it as set, and the following status byte reports it as clear.
- R6: cfgFifoClear high or cfgFifoEn low empties the FIFO and drops the sync lock. Afterwards nothing is stored until a new synchronization word matching the current cfgSyncLow arrives; a word with a stale low byte stores nothing.
- R7: The command byte 0x00 returns an 8-bit status byte, MSB first: bit 7 fillIrq, bit 6 overflow, bit 5 sync locked, bits 4:0 stored count.
- R8: The command byte 0xB0 makes each following data bit pop the oldest stored bit onto spiMiso. A read from an empty FIFO returns 0 and changes nothing.
- R9: spiMosi is taken on spiSck rising edges while spiCsN is low, MSB first, and spiMiso changes after spiSck falling edges. spiMiso is 0 while spiCsN is high. Any other command byte returns zeros and changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitValid | input | 1 | One-cycle strobe marking a received bit |
| bitData | input | 1 | Received bit value |
| cfgSyncLow | input | 8 | Programmable low byte of the synchronization word |
| cfgThreshold | input | THR_W (4) | Fill level that raises fillIrq |
| cfgAlwaysFill | input | 1 | 1: store every bit; 0: store only after the sync word |
| cfgFifoEn | input | 1 | FIFO enable; low empties the FIFO and unlocks |
| cfgFifoClear | input | 1 | Empties the FIFO and unlocks while high |
| spiCsN | input | 1 | Host select, active low |
| spiSck | input | 1 | Host serial clock, oversampled by clk |
| spiMosi | input | 1 | Host command bits |
| spiMiso | output | 1 | Status or FIFO bits to the host |
| fillIrq | output | 1 | Fill-level interrupt |
| overflow | output | 1 | Sticky dropped-bit flag |

## Verification
The payload is delivered under four patterns: noise with no synchronization word, a correct word followed by a payload, a word carrying a stale low byte, and unconditional filling. Together these separate sync-gated storing from always-on storing and show that the word's own bits stay out of the FIFO. A payload sized to land exactly on the threshold locates the interrupt edge to the bit. Filling past sixteen bits, with two status reads in a row, shows that bits are dropped and that the overflow flag is cleared by reading the status. Reads from an empty FIFO and an unknown command show that nothing changes when there is nothing to deliver.

// File: rtl/rxSyncPkg.sv
`timescale 1ns/1ps
package rxSyncPkg;
  localparam int SYNC_W = 16;
  localparam logic [7:0] SYNC_HIGH = 8'h2D;
  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] CMD_STATUS = 8'h00;
  localparam logic [CMD_W-1:0] CMD_READ   = 8'hB0;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic ovfAck;
  } dpStrobes_t;

  typedef enum logic [1:0] {
    HS_CMD,
    HS_STATUS,
    HS_READ,
    HS_IGNORE
  } hostState_t;
endpackage

// File: rtl/rxFifoDp.sv
`timescale 1ns/1ps
module rxFifoDp
  import rxSyncPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitData,
  input  logic [7:0]       syncLow,
  input  dpStrobes_t       strb,
  output logic             syncHit,
  output logic [CNT_W-1:0] fillCount,
  output logic             headBit,
  output logic             ovfFlag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [SYNC_W-2:0] hist;
  logic [SYNC_W-1:0] histNext;
  logic [DEPTH-1:0]  store;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              isFull, isEmpty, doPush, doPop, dropBit;

  assign histNext = {hist, bitData};
  assign syncHit  = bitValid && (histNext == {SYNC_HIGH, syncLow});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hist <= '0;
    else if (strb.flush) hist <= '0;
    else if (bitValid)   hist <= histNext[SYNC_W-2:0];
  end

  assign isFull  = (fillCount == DEPTH_C);
  assign isEmpty = (fillCount == '0);
  assign doPush  = strb.push && !isFull && !strb.flush;
  assign doPop   = strb.pop && !isEmpty && !strb.flush;
  assign dropBit = strb.push && isFull && !strb.flush;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= bitData;
  end

  assign headBit = store[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else if (strb.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (doPush) wrPtr <= stepPtr(wrPtr);
      if (doPop)  rdPtr <= stepPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  // a drop in the acknowledge cycle keeps the flag set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ovfFlag <= 1'b0;
    else if (dropBit)     ovfFlag <= 1'b1;
    else if (strb.ovfAck) ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/rxFifoCtrl.sv
`timescale 1ns/1ps
module rxFifoCtrl
  import rxSyncPkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int THR_W  = 4,
  parameter int STAT_W = CNT_W + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             cfgFifoEn,
  input  logic             cfgFifoClear,
  input  logic             cfgAlwaysFill,
  input  logic [THR_W-1:0] cfgThreshold,
  input  logic             syncHit,
  input  logic [CNT_W-1:0] fillCount,
  input  logic             headBit,
  input  logic             ovfFlag,
  input  logic             spiCsN,
  input  logic             spiSck,
  input  logic             spiMosi,
  output dpStrobes_t       strb,
  output logic             fillIrq,
  output logic             spiMiso
);
  localparam int BCNT_W = $clog2(CMD_W);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(CMD_W - 1);

  logic              synced;
  logic [THR_W-1:0]  thrEff;
  logic              sckQ, sckRise, sckFall;
  logic [CMD_W-2:0]  cmdSh;
  logic [CMD_W-1:0]  cmdWord;
  logic [BCNT_W-1:0] bitCnt;
  hostState_t        hState;
  logic [STAT_W-1:0] statusSh, statusWord;
  logic              cmdDone, statusDecode;

  // fill gating and sync lock
  assign strb.flush = cfgFifoClear || !cfgFifoEn;
  assign strb.push  = bitValid && cfgFifoEn && (cfgAlwaysFill || synced);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           synced <= 1'b0;
    else if (strb.flush) synced <= 1'b0;
    else if (syncHit)    synced <= 1'b1;
  end

  assign thrEff  = (cfgThreshold == '0) ? THR_W'(1) : cfgThreshold;
  assign fillIrq = (fillCount >= CNT_W'(thrEff));

  // host serial port, edges seen in the clk domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckQ <= 1'b0;
    else       sckQ <= spiSck;
  end

  assign sckRise = !spiCsN && spiSck && !sckQ;
  assign sckFall = !spiCsN && !spiSck && sckQ;
  assign cmdWord = {cmdSh, spiMosi};
  assign cmdDone = sckRise && (hState == HS_CMD) && (bitCnt == LAST_BIT);
  assign statusDecode = cmdDone && (cmdWord == CMD_STATUS);
  assign statusWord   = {fillIrq, ovfFlag, synced, fillCount};

  assign strb.ovfAck = statusDecode;
  assign strb.pop    = sckFall && (hState == HS_READ) && (fillCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hState   <= HS_CMD;
      bitCnt   <= '0;
      cmdSh    <= '0;
      statusSh <= '0;
      spiMiso  <= 1'b0;
    end else if (spiCsN) begin
      hState  <= HS_CMD;
      bitCnt  <= '0;
      spiMiso <= 1'b0;
    end else begin
      if (sckRise && hState == HS_CMD) begin
        cmdSh <= cmdWord[CMD_W-2:0];
        if (cmdDone) begin
          bitCnt <= '0;
          if (cmdWord == CMD_STATUS) begin
            hState   <= HS_STATUS;
            statusSh <= statusWord;
          end else if (cmdWord == CMD_READ) begin
            hState <= HS_READ;
          end else begin
            hState <= HS_IGNORE;
          end
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
      if (sckFall) begin
        case (hState)
          HS_STATUS: begin
            spiMiso  <= statusSh[STAT_W-1];
            statusSh <= {statusSh[STAT_W-2:0], 1'b0};
          end
          HS_READ:  spiMiso <= (fillCount != '0) ? headBit : 1'b0;
          default:  spiMiso <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxSyncFifo.sv
`timescale 1ns/1ps
module rxSyncFifo
  import rxSyncPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitData,
  input  logic [7:0]       cfgSyncLow,
  input  logic [THR_W-1:0] cfgThreshold,
  input  logic             cfgAlwaysFill,
  input  logic             cfgFifoEn,
  input  logic             cfgFifoClear,
  input  logic             spiCsN,
  input  logic             spiSck,
  input  logic             spiMosi,
  output logic             spiMiso,
  output logic             fillIrq,
  output logic             overflow
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int STAT_W = CNT_W + 3;

  dpStrobes_t       strb;
  logic             syncHit;
  logic [CNT_W-1:0] fillCount;
  logic             headBit;

  rxFifoCtrl #(.CNT_W(CNT_W), .THR_W(THR_W), .STAT_W(STAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid),
    .cfgFifoEn(cfgFifoEn), .cfgFifoClear(cfgFifoClear),
    .cfgAlwaysFill(cfgAlwaysFill), .cfgThreshold(cfgThreshold),
    .syncHit(syncHit), .fillCount(fillCount), .headBit(headBit),
    .ovfFlag(overflow), .spiCsN(spiCsN), .spiSck(spiSck),
    .spiMosi(spiMosi), .strb(strb), .fillIrq(fillIrq), .spiMiso(spiMiso)
  );

  rxFifoDp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitData(bitData),
    .syncLow(cfgSyncLow), .strb(strb), .syncHit(syncHit),
    .fillCount(fillCount), .headBit(headBit), .ovfFlag(overflow)
  );
endmodule

// File: rtl/rxSyncFifoChk.sv
`timescale 1ns/1ps
module rxSyncFifoChk
  import rxSyncPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input dpStrobes_t       strb,
  input logic [CNT_W-1:0] fillCount,
  input logic             ovfFlag,
  input logic             spiCsN,
  input logic             spiMiso
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  // R1: count never passes capacity
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= DEPTH_C);

  // R1: count grows at most one per cycle
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rstN)
    !strb.flush |=> ({1'b0, fillCount} <= {1'b0, $past(fillCount)} + 1'b1));

  // R5: full FIFO drops the bit and flags it
  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == DEPTH_C && strb.push && !strb.pop && !strb.flush)
      |=> (fillCount == DEPTH_C && ovfFlag));

  // R5: flag holds until acknowledged
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strb.ovfAck) |=> ovfFlag);

  // R6: flush empties the FIFO
  a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (fillCount == '0));

  // R9: idle host line is low
  a_r9_miso_idle: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |=> !spiMiso);
endmodule

bind rxSyncFifo rxSyncFifoChk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .fillCount(fillCount),
  .ovfFlag(overflow), .spiCsN(spiCsN), .spiMiso(spiMiso)
);

// File: tb/test_rxSyncFifo.sv
`timescale 1ns/1ps
module test_rxSyncFifo;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN, bitValid, bitData;
  logic [7:0] cfgSyncLow;
  logic [3:0] cfgThreshold;
  logic       cfgAlwaysFill, cfgFifoEn, cfgFifoClear;
  logic       spiCsN, spiSck, spiMosi;
  logic       spiMiso, fillIrq, overflow;

  rxSyncFifo i_rxSyncFifo (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitData(bitData),
    .cfgSyncLow(cfgSyncLow), .cfgThreshold(cfgThreshold),
    .cfgAlwaysFill(cfgAlwaysFill), .cfgFifoEn(cfgFifoEn),
    .cfgFifoClear(cfgFifoClear), .spiCsN(spiCsN), .spiSck(spiSck),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .fillIrq(fillIrq),
    .overflow(overflow)
  );

  int nTests = 0;
  int nFail  = 0;

  bit        mSynced;
  bit        mOvf;
  bit [14:0] mHist;
  bit        mFifo[$];
  bit        expQ[$];
  bit        gotQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares read bits with expected bits
  initial begin
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0 && expQ.size() > 0) begin
        bit g, e;
        g = gotQ.pop_front();
        e = expQ.pop_front();
        check(g == e, "R8 fifo bit order (R1)", g, e);
      end
    end
  end

  function automatic logic [7:0] expStatus();
    int thr;
    thr = (cfgThreshold == 0) ? 1 : cfgThreshold;
    return {mFifo.size() >= thr, mOvf, mSynced, 5'(mFifo.size())};
  endfunction

  task automatic sendBit(input bit b);
    bit [15:0] win;
    @(negedge clk);
    bitData  = b;
    bitValid = 1'b1;
    if (cfgFifoEn) begin
      if (cfgAlwaysFill || mSynced) begin
        if (mFifo.size() < 16) mFifo.push_back(b);
        else mOvf = 1'b1;
      end
      win   = {mHist, b};
      mHist = win[14:0];
      if (win == {8'h2D, cfgSyncLow}) mSynced = 1'b1;
    end
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic sendBits(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic spiXfer(input logic [7:0] cmd, input int n, input bit isRead,
                         output logic [15:0] data);
    data = '0;
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      spiMosi = cmd[i];
      repeat (4) @(negedge clk);
      spiSck = 1'b1;
      repeat (4) @(negedge clk);
      spiSck = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      repeat (4) @(negedge clk);
      data = {data[14:0], spiMiso};
      if (isRead) begin
        gotQ.push_back(spiMiso);
        if (mFifo.size() > 0) expQ.push_back(mFifo.pop_front());
        else expQ.push_back(1'b0);
      end
      spiSck = 1'b1;
      repeat (4) @(negedge clk);
      if (i != n - 1) spiSck = 1'b0;
    end
    spiCsN = 1'b1;
    repeat (2) @(negedge clk);
    spiSck = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic readStatus(input string req);
    logic [15:0] d;
    logic [7:0]  e;
    e = expStatus();
    spiXfer(8'h00, 8, 1'b0, d);
    mOvf = 1'b0;
    check(d[7:0] == e, req, d[7:0], e);
  endtask

  task automatic readFifo(input int n);
    logic [15:0] d;
    spiXfer(8'hB0, n, 1'b1, d);
    repeat (2) @(negedge clk);
  endtask

  task automatic clearFifo();
    @(negedge clk);
    cfgFifoClear = 1'b1;
    @(negedge clk);
    cfgFifoClear = 1'b0;
    mFifo.delete();
    mSynced = 1'b0;
    mHist   = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    rstN = 1'b0; bitValid = 1'b0; bitData = 1'b0;
    cfgSyncLow = 8'hD4; cfgThreshold = 4'd8; cfgAlwaysFill = 1'b0;
    cfgFifoEn = 1'b0; cfgFifoClear = 1'b0;
    spiCsN = 1'b1; spiSck = 1'b0; spiMosi = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check(fillIrq == 1'b0, "R4 reset irq", fillIrq, 0);
    check(overflow == 1'b0, "R5 reset overflow", overflow, 0);
    check(spiMiso == 1'b0, "R9 reset miso", spiMiso, 0);
    readStatus("R7 reset status");

    cfgFifoEn = 1'b1;
    @(negedge clk);

    // noise without a sync word stores nothing
    sendBits(16'hA5A5, 16);
    readStatus("R2 noise not stored");
    // sync word then 12 payload bits
    sendBits(16'h2DD4, 16);
    check(mSynced == 1'b1, "R2 model locked", mSynced, 1);
    sendBits(16'h0B3C, 12);
    check(fillIrq == 1'b1, "R4 irq above threshold", fillIrq, 1);
    readStatus("R2 payload count after sync");
    readFifo(12);
    check(fillIrq == 1'b0, "R4 irq after drain", fillIrq, 0);

    // threshold edge
    sendBits(16'h0055, 7);
    check(fillIrq == 1'b0, "R4 irq at threshold-1", fillIrq, 0);
    sendBit(1'b1);
    check(fillIrq == 1'b1, "R4 irq at threshold", fillIrq, 1);
    readFifo(1);
    check(fillIrq == 1'b0, "R4 irq falls below threshold", fillIrq, 0);
    readFifo(7);

    // overfill
    sendBits(16'hC3A5, 16);
    check(overflow == 1'b0, "R5 no overflow at full", overflow, 0);
    sendBits(16'h000D, 4);
    check(overflow == 1'b1, "R5 overflow set", overflow, 1);
    readStatus("R5 status shows overflow");
    check(overflow == 1'b0, "R5 overflow cleared by status", overflow, 0);
    readStatus("R5 second status clear");
    readFifo(16);

    // clear and new low byte
    clearFifo();
    readStatus("R6 cleared status");
    cfgSyncLow = 8'h5A;
    sendBits(16'h2DD4, 16);
    readStatus("R6 stale low byte ignored");
    sendBits(16'h2D5A, 16);
    sendBits(16'h0016, 5);
    readStatus("R6 relocked with new low byte");
    readFifo(5);

    // always fill
    clearFifo();
    cfgAlwaysFill = 1'b1;
    sendBits(16'h0269, 10);
    readStatus("R3 always fill count");
    readFifo(10);

    // empty read
    readFifo(3);
    readStatus("R8 empty read leaves state");

    // unknown command
    cfgAlwaysFill = 1'b0;
    sendBits(16'h00A7, 6);
    spiXfer(8'h55, 8, 1'b0, d);
    check(d[7:0] == 8'h00, "R9 unknown command returns zero", d[7:0], 0);
    readStatus("R9 unknown command no state change");
    @(negedge clk);
    check(spiMiso == 1'b0, "R9 miso idle", spiMiso, 0);
    readFifo(6);

    // disable empties and unlocks
    sendBits(16'h0005, 3);
    cfgFifoEn = 1'b0;
    @(negedge clk);
    mFifo.delete(); mSynced = 1'b0; mHist = '0;
    sendBits(16'h00FF, 8);
    cfgFifoEn = 1'b1;
    @(negedge clk);
    readStatus("R6 disable empties fifo");

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R8 scoreboard drained", expQ.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule